// File: doc/BRIEF.md
# Hash Engine Register Front End

This block lets a processor drive a 160-bit digest hash engine over a small memory-mapped bus. Software loads a 512-bit message block as sixteen 32-bit words. It then writes a command word to start the engine. A start-of-message command hashes from the engine's initial value. A continue command chains from the digest left by the previous block, so a long message is hashed one block at a time. Software polls a status word for the ready and digest-valid flags and reads the 160-bit result back as five 32-bit words.

Each bus transfer takes one cycle. It is qualified by a select strobe, and a write strobe chooses between write and read. Read data and the error flag are combinational in the same cycle. Writes take effect at the closing clock edge. The engine itself sits outside this block and connects through plain ports.

Top module: `hash_regif`

## Requirements
- R1: After the active-low asynchronous reset, every message word reads 0, both command outputs are 0 and the 512-bit block output is 0.
- R2: Reads of address 0x00 and 0x01 return the two identification words, and a read of 0x02 returns the version word.
- R3: A write to address 0x10+i (i = 0..15) stores the data in message word i, and a later read of that address returns it.
- R4: The 512-bit block output is the concatenation of the message words, with word 0 (address 0x10) in bits 511:480 and word 15 in bits 31:0.
- R5: A write to the command address 0x08 with bit 0 set raises the start output for exactly the one cycle after the write edge. Bit 1 does the same for the continue output. A write with a bit clear leaves that output low.
- R6: A read of address 0x09 returns the engine ready flag in bit 0 and the digest-valid flag in bit 1, each as sampled at the clock edge before the read cycle. All other bits are 0.
- R7: Reads of addresses 0x20..0x24 return the digest sampled at the previous edge. Address 0x20 gives bits 159:128 and each higher address gives the next lower 32 bits.
- R8: A write to a read-only address (0x00..0x02, 0x09, 0x20..0x24) raises the error output in that cycle and changes no stored state.
- R9: Any read or write at an address outside the map raises the error output and changes no stored state. Such a read returns 0.
- R10: The error output stays low when the select strobe is low and for every legal access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Transfer select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the read cycle |
| bus_err | output | 1 | Illegal access flag |
| eng_start | output | 1 | One-cycle start-of-message command |
| eng_cont | output | 1 | One-cycle continue-chain command |
| eng_block | output | 512 | Message block to the engine |
| eng_ready | input | 1 | Engine idle flag |
| eng_digest | input | 160 | Engine result |
| eng_dvalid | input | 1 | Engine result valid |

## Verification
The assertions check on every cycle that each command output lasts one cycle and always follows a command write. They also check that the status and digest copies lag the engine by exactly one edge, that a stored message word equals the data written, and that an erroring write leaves the block output untouched. The bench's scenarios show the parts the assertions cannot: the address map, the word order of the 512-bit block and of the split digest, and the start-then-continue chaining across two blocks. A stand-in engine with a known result function drives these scenarios.

// File: rtl/hif_pkg.sv
package hif_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned WORD_W = 32;

  localparam logic [ADDR_W-1:0] A_ID0  = 8'h00;
  localparam logic [ADDR_W-1:0] A_ID1  = 8'h01;
  localparam logic [ADDR_W-1:0] A_VER  = 8'h02;
  localparam logic [ADDR_W-1:0] A_CMD  = 8'h08;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h09;
  localparam logic [ADDR_W-1:0] A_MSG0 = 8'h10;
  localparam logic [ADDR_W-1:0] A_DIG0 = 8'h20;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_ID,
    RG_CMD,
    RG_STAT,
    RG_MSG,
    RG_DIG
  } region_e;

  function automatic logic region_is_ro(region_e r);
    return (r == RG_ID) || (r == RG_STAT) || (r == RG_DIG);
  endfunction

  function automatic logic in_window(logic [ADDR_W-1:0] a,
                                     logic [ADDR_W-1:0] base,
                                     int unsigned       count);
    return ({1'b0, a} >= {1'b0, base}) &&
           ({1'b0, a} <  ({1'b0, base} + (ADDR_W+1)'(count)));
  endfunction
endpackage

// File: rtl/hif_decode.sv
module hif_decode
  import hif_pkg::*;
#(
  parameter int unsigned MSG_WORDS = 16,
  parameter int unsigned DIG_WORDS = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [ADDR_W-1:0] offset
);
  always_comb begin
    region = RG_NONE;
    offset = '0;
    if (addr == A_ID0 || addr == A_ID1 || addr == A_VER) begin
      region = RG_ID;
      offset = addr - A_ID0;
    end else if (addr == A_CMD) begin
      region = RG_CMD;
    end else if (addr == A_STAT) begin
      region = RG_STAT;
    end else if (in_window(addr, A_MSG0, MSG_WORDS)) begin
      region = RG_MSG;
      offset = addr - A_MSG0;
    end else if (in_window(addr, A_DIG0, DIG_WORDS)) begin
      region = RG_DIG;
      offset = addr - A_DIG0;
    end
  end
endmodule

// File: rtl/hif_cmd.sv
module hif_cmd (
  input  logic clk,
  input  logic rst_n,
  input  logic set_start,
  input  logic set_cont,
  output logic start_q,
  output logic cont_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      cont_q  <= 1'b0;
    end else begin
      start_q <= set_start;
      cont_q  <= set_cont;
    end
  end

  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  p_cont_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cont_q |=> !cont_q);
  p_start_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_q) |-> $past(set_start));
endmodule

// File: rtl/hif_msg_regs.sv
module hif_msg_regs #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WORDS  = 16,
  localparam int unsigned IDX_W = $clog2(WORDS),
  localparam int unsigned FLAT_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic [FLAT_W-1:0] flat
);
  logic [WORD_W-1:0] word_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic hit;
    assign hit = we && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[g] <= '0;
      else if (hit) word_q[g] <= wdata;
    end
    assign flat[FLAT_W-1-g*WORD_W -: WORD_W] = word_q[g];
  end

  assign rd_word = word_q[rd_idx];

  p_msg_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (word_q[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/hif_capture.sv
module hif_capture #(
  parameter int unsigned DIG_W = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready_in,
  input  logic             dvalid_in,
  input  logic [DIG_W-1:0] digest_in,
  output logic [1:0]       stat_q,
  output logic [DIG_W-1:0] digest_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q   <= '0;
      digest_q <= '0;
    end else begin
      stat_q   <= {dvalid_in, ready_in};
      digest_q <= digest_in;
    end
  end

  p_status_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stat_q == {$past(dvalid_in), $past(ready_in)}));
  p_digest_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (digest_q == $past(digest_in)));
endmodule

// File: rtl/hash_regif.sv
module hash_regif
  import hif_pkg::*;
#(
  parameter int unsigned MSG_WORDS = 16,
  parameter int unsigned DIG_WORDS = 5,
  parameter logic [31:0] ID_WORD0  = 32'h68617368,
  parameter logic [31:0] ID_WORD1  = 32'h2d726567,
  parameter logic [31:0] VER_WORD  = 32'h00010002,
  localparam int unsigned BLK_W    = WORD_W * MSG_WORDS,
  localparam int unsigned DIG_W    = WORD_W * DIG_WORDS,
  localparam int unsigned MIDX_W   = $clog2(MSG_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              eng_start,
  output logic              eng_cont,
  output logic [BLK_W-1:0]  eng_block,
  input  logic              eng_ready,
  input  logic [DIG_W-1:0]  eng_digest,
  input  logic              eng_dvalid
);
  region_e           region;
  logic [ADDR_W-1:0] offset;
  logic              acc_illegal;
  logic              wr_ok;
  logic              cmd_wr_ev;
  logic              msg_wr_ev;
  logic [WORD_W-1:0] msg_rd;
  logic [1:0]        stat_q;
  logic [DIG_W-1:0]  digest_q;
  logic [WORD_W-1:0] dig_word [DIG_WORDS];
  logic [WORD_W-1:0] id_word;

  hif_decode #(.MSG_WORDS(MSG_WORDS), .DIG_WORDS(DIG_WORDS)) u_dec (
    .addr(bus_addr), .region(region), .offset(offset)
  );

  assign acc_illegal = (region == RG_NONE) || (bus_wr && region_is_ro(region));
  assign bus_err     = bus_sel && acc_illegal;
  assign wr_ok       = bus_sel && bus_wr && !acc_illegal;
  assign cmd_wr_ev   = wr_ok && (region == RG_CMD);
  assign msg_wr_ev   = wr_ok && (region == RG_MSG);

  hif_cmd u_cmd (
    .clk(clk), .rst_n(rst_n),
    .set_start(cmd_wr_ev && bus_wdata[0]),
    .set_cont(cmd_wr_ev && bus_wdata[1]),
    .start_q(eng_start), .cont_q(eng_cont)
  );

  hif_msg_regs #(.WORD_W(WORD_W), .WORDS(MSG_WORDS)) u_msg (
    .clk(clk), .rst_n(rst_n),
    .we(msg_wr_ev), .idx(offset[MIDX_W-1:0]), .wdata(bus_wdata),
    .rd_idx(offset[MIDX_W-1:0]), .rd_word(msg_rd), .flat(eng_block)
  );

  hif_capture #(.DIG_W(DIG_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .ready_in(eng_ready), .dvalid_in(eng_dvalid), .digest_in(eng_digest),
    .stat_q(stat_q), .digest_q(digest_q)
  );

  for (genvar k = 0; k < DIG_WORDS; k++) begin : g_dig
    assign dig_word[k] = digest_q[DIG_W-1-k*WORD_W -: WORD_W];
  end

  always_comb begin
    case (offset[1:0])
      2'd0:    id_word = ID_WORD0;
      2'd1:    id_word = ID_WORD1;
      default: id_word = VER_WORD;
    endcase
  end

  always_comb begin
    bus_rdata = '0;
    case (region)
      RG_ID:   bus_rdata = id_word;
      RG_CMD:  bus_rdata = {{(WORD_W-2){1'b0}}, eng_cont, eng_start};
      RG_STAT: bus_rdata = {{(WORD_W-2){1'b0}}, stat_q};
      RG_MSG:  bus_rdata = msg_rd;
      RG_DIG:  bus_rdata = dig_word[offset[$clog2(DIG_WORDS)-1:0]];
      default: bus_rdata = '0;
    endcase
  end

  p_bad_write_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_err) |=> $stable(eng_block));
  p_bad_write_nocmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_err) |=> (!eng_start && !eng_cont));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> !bus_err);
  p_cmd_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start || eng_cont) |-> $past(bus_sel && bus_wr && (bus_addr == A_CMD)));
endmodule

// File: tb/tb_hash_regif.sv
module tb_hash_regif;
  localparam int CLK_PERIOD = 10;
  localparam int ENG_LAT    = 6;
  localparam logic [159:0] IV = 160'h0123456789abcdeffedcba9876543210f0e1d2c3;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         bus_sel = 0, bus_wr = 0;
  logic [7:0]   bus_addr = 0;
  logic [31:0]  bus_wdata = 0;
  logic [31:0]  bus_rdata;
  logic         bus_err;
  logic         eng_start, eng_cont;
  logic [511:0] eng_block;
  logic         eng_ready;
  logic [159:0] eng_digest;
  logic         eng_dvalid;

  int n_checks = 0, n_errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hash_regif dut (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .eng_start(eng_start), .eng_cont(eng_cont), .eng_block(eng_block),
    .eng_ready(eng_ready), .eng_digest(eng_digest), .eng_dvalid(eng_dvalid)
  );

  // stand-in engine with a known result function
  function automatic logic [159:0] stub_mix(logic [511:0] b, logic [159:0] c);
    return (c + b[511:352]) ^ b[159:0];
  endfunction

  int eng_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_ready <= 1'b1; eng_dvalid <= 1'b0; eng_digest <= '0; eng_cnt <= 0;
    end else if (eng_start || eng_cont) begin
      eng_ready  <= 1'b0;
      eng_dvalid <= 1'b0;
      eng_cnt    <= ENG_LAT;
      eng_digest <= stub_mix(eng_block, eng_start ? IV : eng_digest);
    end else if (eng_cnt > 1) begin
      eng_cnt <= eng_cnt - 1;
    end else if (eng_cnt == 1) begin
      eng_cnt <= 0; eng_ready <= 1'b1; eng_dvalid <= 1'b1;
    end
  end

  // scoreboard queues
  logic [31:0] q_data[$];
  bit          q_err[$];
  bit          q_cmp[$];
  string       q_tag[$];

  task automatic check(string tag, logic [511:0] act, logic [511:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bus_sel) begin
      if (q_tag.size() == 0) begin
        n_checks++; n_errors++;
        $display("FAIL scoreboard: actual=access expected=none");
      end else begin
        string t; logic [31:0] d; bit e; bit c;
        t = q_tag.pop_front(); d = q_data.pop_front();
        e = q_err.pop_front(); c = q_cmp.pop_front();
        check({t, " err"}, 512'(bus_err), 512'(e));
        if (c) check({t, " rdata"}, 512'(bus_rdata), 512'(d));
      end
    end
  end

  task automatic acc(bit wr, logic [7:0] a, logic [31:0] wd,
                     logic [31:0] exp_d, bit exp_e, bit cmp, string tag);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    q_data.push_back(exp_d); q_err.push_back(exp_e);
    q_cmp.push_back(cmp); q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic write_block(logic [511:0] b);
    for (int i = 0; i < 16; i++)
      acc(1, 8'h10 + 8'(i), b[511-32*i -: 32], 0, 0, 0, "R3");
  endtask

  task automatic wait_done();
    idle();
    while (!(eng_ready && eng_dvalid)) idle();
    idle(); idle();
  endtask

  task automatic read_digest(logic [159:0] d, string tag);
    for (int k = 0; k < 5; k++)
      acc(0, 8'h20 + 8'(k), 0, d[159-32*k -: 32], 0, 1, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [511:0] blk_a, blk_b;
    logic [159:0] dig_a, dig_b;
    blk_a = {16{32'h0}};
    for (int i = 0; i < 16; i++) blk_a[511-32*i -: 32] = 32'h1000_0000 * (i + 1) + 32'h0000_0a5c * i;
    blk_b = ~blk_a ^ {16{32'h3c3c_5a5a}};
    dig_a = stub_mix(blk_a, IV);
    dig_b = stub_mix(blk_b, dig_a);

    #(3*CLK_PERIOD + 2); rst_n = 1;
    idle();
    // R1 reset state
    check("R1 block", eng_block, '0);
    check("R1 start", 512'(eng_start), 0);
    check("R1 cont",  512'(eng_cont), 0);
    acc(0, 8'h10, 0, 0, 0, 1, "R1 word0");
    acc(0, 8'h1f, 0, 0, 0, 1, "R1 word15");
    // R2 identification
    acc(0, 8'h00, 0, 32'h68617368, 0, 1, "R2 id0");
    acc(0, 8'h01, 0, 32'h2d726567, 0, 1, "R2 id1");
    acc(0, 8'h02, 0, 32'h00010002, 0, 1, "R2 ver");
    // R3 / R4 block
    write_block(blk_a);
    idle();
    check("R4 block", eng_block, blk_a);
    check("R4 word0 msb", 512'(eng_block[511:480]), 512'(blk_a[511:480]));
    acc(0, 8'h10, 0, blk_a[511:480], 0, 1, "R3 rb0");
    acc(0, 8'h17, 0, blk_a[511-32*7 -: 32], 0, 1, "R3 rb7");
    acc(0, 8'h1f, 0, blk_a[31:0], 0, 1, "R3 rb15");
    // R8 writes to read-only addresses
    acc(1, 8'h20, 32'hdead_beef, 0, 1, 0, "R8 dig");
    acc(1, 8'h09, 32'h3, 0, 1, 0, "R8 stat");
    acc(1, 8'h00, 32'h1234, 0, 1, 0, "R8 id");
    acc(0, 8'h00, 0, 32'h68617368, 0, 1, "R8 id kept");
    // R9 unmapped
    acc(1, 8'h05, 32'h1, 0, 1, 0, "R9 wr");
    acc(0, 8'h25, 0, 0, 1, 1, "R9 rd");
    acc(0, 8'hff, 0, 0, 1, 1, "R9 rd top");
    idle();
    check("R9 no cmd", 512'({eng_start, eng_cont}), 0);
    check("R9 block kept", eng_block, blk_a);
    // R10: legal command read has no error
    acc(0, 8'h08, 0, 0, 0, 1, "R10 cmd rd");
    idle();
    check("R10 idle err", 512'(bus_err), 0);
    // R5 start pulse, R6 status lag
    acc(1, 8'h08, 32'h1, 0, 0, 0, "R5 wr");
    idle();
    check("R5 start hi", 512'(eng_start), 1);
    check("R5 cont lo", 512'(eng_cont), 0);
    acc(0, 8'h09, 0, 32'h1, 0, 1, "R6 stale ready");
    check("R5 start lo", 512'(eng_start), 0);
    acc(0, 8'h09, 0, 32'h0, 0, 1, "R6 busy");
    wait_done();
    acc(0, 8'h09, 0, 32'h3, 0, 1, "R6 done");
    read_digest(dig_a, "R7 first");
    // R5 continue chaining
    write_block(blk_b);
    acc(1, 8'h08, 32'h2, 0, 0, 0, "R5 wr cont");
    idle();
    check("R5 cont hi", 512'(eng_cont), 1);
    check("R5 start lo2", 512'(eng_start), 0);
    idle();
    check("R5 cont lo", 512'(eng_cont), 0);
    wait_done();
    read_digest(dig_b, "R7 chained");
    idle(); idle();
    check("scoreboard drained", 512'(q_tag.size()), 0);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule